// File: doc/BRIEF.md
# Multi-Phase Shared-Period PWM Timer

This block generates up to seven PWM waveforms that share one period. A single 16-bit up-counter runs whenever the enable input is high. Eight compare slots sit beside it. Configuration picks one slot as the period source, and the remaining slots each set the duty of their own output pin. A match against the period slot clears the counter on the next clock and returns every pin to its configured start level. A match against a duty slot applies that pin's two-bit match action.

Software loads the compare values and the period-slot choice through a small write port. These writes land in a shadow copy. The working copy takes them over only at a period clear, or at any time while the timer is stopped, so a waveform never changes in the middle of a period. The start level and match action of each pin are static configuration inputs, and they are changed only while the timer is stopped.

Top module: `mpwm_timer`

## Requirements
- R1: While enabled, the 16-bit counter starts at 0 and rises by exactly one on every clock. With period value P, the counter visits 0..P in order.
- R2: In the cycle where the counter equals the value in the period slot, the counter returns to 0 at the next clock. One PWM period therefore lasts P+1 clocks.
- R3: On the clock that clears the counter, every pin is set to its start level from `init_lvl`.
- R4: In the cycle where the counter equals a pin's duty value D (with D below P), the next clock applies that pin's action code from `pin_act[2i+1:2i]`. The codes are 00 hold, 01 drive 0, 10 drive 1, 11 invert. With start level 0 and action 10, the pin is high for P-D clocks of each period.
- R5: A duty value equal to the period value never changes its pin, so the pin stays at its start level for the whole period. A duty value above P never matches either.
- R6: The pin whose index equals the selected period slot gives no PWM. It stays at its start level.
- R7: Write addresses 0..7 load compare slots 0..7 from `wr_data`. Address 8 loads the period-slot selection from `wr_data[2:0]`. Any of the eight slots may be chosen.
- R8: While `en` is low, the counter holds at 0 and every pin shows its start level one clock later. Raising `en` restarts the counting from 0.
- R9: Values written while running are buffered. They take effect only at the next period clear. While stopped, a write takes effect within two clocks.
- R10: Writes to addresses 9..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; low stops and parks all pins |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 4 | Slot address (0..7 compare, 8 period select) |
| wr_data | input | 16 | Write data |
| init_lvl | input | 8 | Start level of each pin |
| pin_act | input | 16 | Two-bit match action per pin, pin i at bits 2i+1:2i |
| pwm_out | output | 8 | One PWM pin per compare slot |

## Verification
The in-RTL assertions take two things for granted. First, `init_lvl` and `pin_act` stay steady while the timer runs. Second, the timer spends at least one clock with `en` low after reset before it counts. The directed bench keeps to both: it changes the pin configuration only with `en` low, and it holds `en` low for several clocks after every reset and before every restart. Compare values and the period choice are written both while stopped and while running. The running writes exercise the shadow hand-over, including a move of the period slot to another index.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } pin_act_e;

  // Level a pin takes when its duty compare fires.
  function automatic logic apply_act(input logic [1:0] act, input logic cur);
    logic nxt;
    unique case (pin_act_e'(act))
      ACT_HOLD:   nxt = cur;
      ACT_LOW:    nxt = 1'b0;
      ACT_HIGH:   nxt = 1'b1;
      ACT_INVERT: nxt = ~cur;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

  // A duty slot only fires when its value lies strictly below the period.
  function automatic logic duty_fires(input logic [15:0] duty, input logic [15:0] prd);
    return duty < prd;
  endfunction

endpackage

// File: rtl/mpwm_counter.sv
module mpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] prd_val,
  output logic [CNT_W-1:0] cnt,
  output logic             prd_hit
);

  assign prd_hit = en && (cnt == prd_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (prd_hit) cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && !prd_hit |=> cnt == $past(cnt) + CNT_W'(1)); // R1
  AST_CLEAR_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    prd_hit |=> cnt == '0); // R2
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= prd_val); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0); // R8

endmodule

// File: rtl/mpwm_cmp_bank.sv
module mpwm_cmp_bank #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = $clog2(NUM_CH),
  parameter int AW     = SEL_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic                         load,
  output logic [NUM_CH-1:0][CNT_W-1:0] act_cmp,
  output logic [SEL_W-1:0]             act_sel
);

  localparam logic [AW-1:0] SEL_ADDR = AW'(NUM_CH);

  logic [NUM_CH-1:0][CNT_W-1:0] shd_cmp;
  logic [SEL_W-1:0]             shd_sel;
  logic                         sel_wr;

  assign sel_wr = wr_en && (wr_addr == SEL_ADDR);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic slot_wr;
    assign slot_wr = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       shd_cmp[g] <= '0;
      else if (slot_wr) shd_cmp[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_cmp[g] <= '0;
      else if (load) act_cmp[g] <= shd_cmp[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shd_sel <= '0;
    else if (sel_wr) shd_sel <= wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_sel <= '0;
    else if (load) act_sel <= shd_sel;
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_cmp) && $stable(act_sel)); // R9
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> act_sel == $past(shd_sel)); // R7

endmodule

// File: rtl/mpwm_pin_ctl.sv
module mpwm_pin_ctl
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] prd_val,
  input  logic             is_prd,
  input  logic             prd_hit,
  input  logic             init_lvl,
  input  logic [1:0]       act,
  output logic             duty_hit,
  output logic             pin
);

  assign duty_hit = en && !is_prd && (cnt == duty) && duty_fires(duty, prd_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pin <= 1'b0;
    else if (!en)              pin <= init_lvl;
    else if (prd_hit || is_prd) pin <= init_lvl;
    else if (duty_hit)         pin <= apply_act(act, pin);
  end

  AST_IDLE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pin == $past(init_lvl)); // R8
  AST_CLEAR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    prd_hit |=> pin == $past(init_lvl)); // R3
  AST_PRD_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    en && is_prd |=> pin == $past(init_lvl)); // R6
  AST_EQ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en && !is_prd && !prd_hit && duty >= prd_val |=> $stable(pin)); // R5
  AST_ACT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    duty_hit && !prd_hit && act == 2'b10 |=> pin); // R4
  AST_ACT_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    duty_hit && !prd_hit && act == 2'b11 |=> pin != $past(pin)); // R4

endmodule

// File: rtl/mpwm_timer.sv
module mpwm_timer #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = $clog2(NUM_CH),
  parameter int AW     = SEL_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [NUM_CH-1:0]   init_lvl,
  input  logic [2*NUM_CH-1:0] pin_act,
  output logic [NUM_CH-1:0]   pwm_out
);

  logic [NUM_CH-1:0][CNT_W-1:0] act_cmp;
  logic [SEL_W-1:0]             act_sel;
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             prd_val;
  logic                         prd_hit;
  logic                         load;
  logic [NUM_CH-1:0]            duty_hit;

  assign prd_val = act_cmp[act_sel];
  assign load    = !en || prd_hit;

  mpwm_cmp_bank #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W),
    .AW     (AW)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (load),
    .act_cmp (act_cmp),
    .act_sel (act_sel)
  );

  mpwm_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .prd_val (prd_val),
    .cnt     (cnt),
    .prd_hit (prd_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
    logic is_prd;
    assign is_prd = (act_sel == SEL_W'(g));

    mpwm_pin_ctl #(
      .CNT_W (CNT_W)
    ) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .cnt      (cnt),
      .duty     (act_cmp[g]),
      .prd_val  (prd_val),
      .is_prd   (is_prd),
      .prd_hit  (prd_hit),
      .init_lvl (init_lvl[g]),
      .act      (pin_act[2*g+1:2*g]),
      .duty_hit (duty_hit[g]),
      .pin      (pwm_out[g])
    );
  end

  AST_HITS_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> duty_hit == '0 && !prd_hit); // R8
  AST_PRD_SLOT_NEVER_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    duty_hit[act_sel] == 1'b0); // R6

endmodule

// File: tb/mpwm_timer_tb.sv
`timescale 1ns/1ps
module mpwm_timer_tb;

  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  init_lvl = '0;
  logic [15:0] pin_act = '0;
  logic [7:0]  pwm_out;

  int vectors = 0;
  int errors  = 0;
  string tag = "R8";

  // bench model state
  int m_shd[NCH];
  int m_act[NCH];
  int m_shd_sel = 0;
  int m_sel = 0;
  int mc = 0;
  logic [7:0] expv = '0;

  always #5 clk = ~clk;

  mpwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .init_lvl(init_lvl), .pin_act(pin_act), .pwm_out(pwm_out)
  );

  function automatic logic act_of(input logic [1:0] a, input logic lvl);
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~lvl;
      default: return lvl;
    endcase
  endfunction

  // Level after the edge that saw counter value c.
  function automatic logic model_pin(input int i, input int c);
    int p, d;
    p = m_act[m_sel];
    d = m_act[i];
    if (i == m_sel || c == p || d >= p || c < d) return init_lvl[i];
    return act_of(pin_act[2*i +: 2], init_lvl[i]);
  endfunction

  function automatic int high_time(input int p, input int d);
    return p - d;
  endfunction

  task automatic check(input logic [7:0] act_v, input logic [7:0] exp_v, input string t);
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: pwm_out=%b expected %b (t=%0t)", t, act_v, exp_v, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (en) begin
      for (int i = 0; i < NCH; i++) expv[i] = model_pin(i, mc);
      if (mc == m_act[m_sel]) begin
        mc = 0;
        for (int i = 0; i < NCH; i++) m_act[i] = m_shd[i];
        m_sel = m_shd_sel;
      end else mc++;
    end else begin
      mc = 0;
      expv = init_lvl;
      for (int i = 0; i < NCH; i++) m_act[i] = m_shd[i];
      m_sel = m_shd_sel;
    end
    if (wr_en) begin
      if (wr_addr < 4'd8) m_shd[wr_addr] = int'(wr_data);
      else if (wr_addr == 4'd8) m_shd_sel = int'(wr_data[2:0]);
    end
    @(negedge clk);
    check(pwm_out, expv, tag);
  endtask

  task automatic write(input logic [3:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic stop_and_idle();
    en = 1'b0;
    run(3);
  endtask

  // R8: parked levels after reset
  task automatic t_reset();
    tag = "R8";
    init_lvl = 8'hA5;
    run(3);
    check(pwm_out, 8'hA5, "R8");
  endtask

  // R1 R2 R4 R5: slot 7 is the period, mixed duty values, drive-high action
  task automatic t_basic();
    int hi;
    tag = "R4";
    init_lvl = 8'h00;
    pin_act  = {8{2'b10}};
    write(4'd7, 9);
    write(4'd0, 0); write(4'd1, 3); write(4'd2, 5);
    write(4'd3, 9); write(4'd4, 12); write(4'd5, 1); write(4'd6, 8);
    write(4'd8, 7);
    run(2);
    en = 1'b1;
    hi = 0;
    for (int j = 0; j < 30; j++) begin
      tag = (j % 10 == 9) ? "R2" : "R1";
      step();
      if (j >= 10 && j <= 19 && pwm_out[1]) hi++;
      if (pwm_out[3] !== 1'b0) begin
        errors++; $display("FAIL R5: pin3=%b expected 0", pwm_out[3]);
      end
      vectors++;
    end
    vectors++;
    if (hi != high_time(9, 3)) begin
      errors++; $display("FAIL R4: high time %0d expected %0d", hi, high_time(9, 3));
    end
    stop_and_idle();
  endtask

  // R3 R6 R7: slot 0 is the period, mixed start levels and all action codes
  task automatic t_actions();
    tag = "R3";
    init_lvl = 8'b1011_0110;
    pin_act  = {2'b11, 2'b01, 2'b00, 2'b10, 2'b11, 2'b01, 2'b10, 2'b11};
    write(4'd0, 6);
    write(4'd1, 2); write(4'd2, 0); write(4'd3, 4); write(4'd4, 5);
    write(4'd5, 3); write(4'd6, 1); write(4'd7, 6);
    write(4'd8, 0);
    run(2);
    en = 1'b1;
    tag = "R6";
    run(21);
    stop_and_idle();
    tag = "R7";
    check(pwm_out, init_lvl, "R7");
  endtask

  // R9 R7 R10: rewrite duties and move the period slot while running
  task automatic t_move();
    tag = "R9";
    init_lvl = 8'h0F;
    pin_act  = {8{2'b11}};
    write(4'd3, 12);
    for (int i = 0; i < NCH; i++) if (i != 3) write(4'(i), i + 2);
    write(4'd8, 3);
    run(2);
    en = 1'b1;
    run(5);
    write(4'd5, 1);
    write(4'd6, 11);
    write(4'd0, 7);
    write(4'd8, 0);
    run(30);
    tag = "R10";
    for (int a = 9; a < 16; a++) write(4'(a), 16'h0003);
    run(20);
    stop_and_idle();
  endtask

  // R8: dropping en mid-period restarts counting from 0
  task automatic t_disable();
    tag = "R8";
    init_lvl = 8'h00;
    pin_act  = {8{2'b10}};
    write(4'd2, 10);
    for (int i = 0; i < NCH; i++) if (i != 2) write(4'(i), i);
    write(4'd8, 2);
    run(2);
    en = 1'b1;
    run(7);
    en = 1'b0;
    step();
    check(pwm_out, 8'h00, "R8");
    run(2);
    en = 1'b1;
    run(25);
    stop_and_idle();
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin m_shd[i] = 0; m_act[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_actions();
    t_move();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule